// File: doc/BRIEF.md
# Multi-Channel Input Capture Timer

This block keeps one 16-bit timebase that counts up freely. It advances once every `PRESCALE` clocks, and software can neither stop it nor load it. Three event inputs are each watched for one chosen edge, rising or falling. When that edge arrives, the current timebase value is copied into the input's capture register. A per-input status flag is set at the same moment. That flag can drive a shared interrupt line if its enable bit is set.

The first two capture registers are shared with a general-purpose down-counting reload timer. While the pair-capture mode bit is clear, that storage works as a reload timer: a reload register and a down counter that steps with the timebase and emits an underflow pulse. Edges on inputs 0 and 1 are ignored in this mode. While the mode bit is set, the timer stops, and the two storage words become capture registers for inputs 0 and 1.

Software reaches the block through a flat register port: address, write enable, write data, and a combinational read data bus.

Top module: `ctmr_top`

## Requirements
- R1: After reset the timebase reads 0 at address 0. It rises by exactly one every `PRESCALE` clocks and wraps from 0xFFFF to 0.
- R2: A write to address 0 has no effect on the timebase.
- R3: Each event input passes through a two-flop synchroniser. If a pin changes before clock edge k, its capture register is updated at edge k+2. The value stored is the one the timebase holds after that edge. Input i's capture register reads at address 3+i.
- R4: Control register at address 1 holds three fields: bit 0 is the pair-capture mode, bits 3:1 select the edge for inputs 0..2 (0 = rising, 1 = falling), and bits 6:4 are the interrupt enables for inputs 0..2. A capture happens only on the selected edge.
- R5: Status register at address 2 holds three sticky capture flags in bits 2:0 and three overrun bits in bits 5:3. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: `irq` is high exactly when some capture flag is set and its interrupt enable is set.
- R7: A capture while the input's flag is already set (and not being cleared in that cycle) still overwrites the capture register, and it sets that input's overrun bit.
- R8: With mode 0, edges on inputs 0 and 1 cause no capture and no flag. Address 3 is then a reload register and address 4 a down counter. On each timebase step the counter decrements; when it is 0 it reloads instead and pulses `underflow` high for one clock.
- R9: With mode 1, the down counter is frozen apart from captures and software writes. Input 0 captures into address 3 and input 1 captures into address 4.
- R10: A capture in the same cycle as a timebase step, including the 0xFFFF to 0 wrap, stores the post-step value.
- R11: While reset is asserted, every register reads 0 and `irq` and `underflow` are low.
- R12: When a capture and a software write to the same capture register fall in one cycle, the capture is kept. When a capture and a write-1 clear of its flag fall in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 3 | Asynchronous event inputs |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| underflow | output | 1 | One-clock reload timer underflow pulse |

## Verification
Three collisions are provoked on purpose, each by timing a pin change so its capture lands on a chosen clock edge.

- **Capture and timebase step.** A capture is made to land on the same edge as a timebase step, and once right on the 0xFFFF to 0 wrap. The bench judges it by whether the stored value is the post-step count.
- **Capture and status clear.** A capture is made to share its edge with a write-1 clear of that input's status. The flag must survive and the overrun bit must not be raised.
- **Capture and register write.** A capture is made to meet a software write to the same capture register. The captured value must win.

A behavioural model in the bench predicts every register, `irq` and `underflow` on each clock.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int CH_COUNT = 3;
  localparam int ADR_COUNT = 0;
  localparam int ADR_CTRL = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_CAP0 = 3;
  localparam int CTRL_W = 2 * CH_COUNT + 1;
  localparam int STAT_W = 2 * CH_COUNT;

  typedef struct packed {
    logic [CH_COUNT-1:0] cap;
    logic wrReload;
    logic wrTimer;
    logic pairCapture;
  } ctmr_strb_t;
endpackage

// File: rtl/ctmr_datapath.sv
module ctmr_datapath
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  ctmr_strb_t strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capRegs [CH_COUNT],
  output logic underflow
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic tick;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] tmrReg;

  generate
    if (PRESCALE == 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] preCnt;
      assign tick = (preCnt == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (!rstN) preCnt <= '0;
        else if (tick) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
    end
  endgenerate

  // Captures take the value the timebase holds after this edge
  assign countNext = tick ? count + 1'b1 : count;

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else count <= countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) reloadReg <= '0;
    else if (strb.cap[0]) reloadReg <= countNext;
    else if (strb.wrReload) reloadReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrReg <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= 1'b0;
      if (strb.cap[1]) tmrReg <= countNext;
      else if (strb.wrTimer) tmrReg <= wrData;
      else if (!strb.pairCapture && tick) begin
        if (tmrReg == '0) begin
          tmrReg <= reloadReg;
          underflow <= 1'b1;
        end else begin
          tmrReg <= tmrReg - 1'b1;
        end
      end
    end
  end

  assign capRegs[0] = reloadReg;
  assign capRegs[1] = tmrReg;

  generate
    for (genvar i = 2; i < CH_COUNT; i++) begin : g_cap
      logic [CNT_W-1:0] capReg;
      always_ff @(posedge clk) begin
        if (!rstN) capReg <= '0;
        else if (strb.cap[i]) capReg <= countNext;
      end
      assign capRegs[i] = capReg;
    end
  endgenerate
endmodule

// File: rtl/ctmr_control.sv
module ctmr_control
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [CH_COUNT-1:0] evtIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic [CNT_W-1:0] wrData,
  output ctmr_strb_t strb,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [STAT_W-1:0] statWord,
  output logic irq
);
  logic [CH_COUNT-1:0] syncA, syncB, syncPrev;
  logic [CH_COUNT-1:0] edgeHit, capEn;
  logic [CH_COUNT-1:0] edgePol, irqEn, flags, ovr;
  logic [CH_COUNT-1:0] clrFlag, clrOvr;
  logic pairMode;
  logic wrCtrl, wrStat;

  assign wrCtrl = wrEn && (addr == ADDR_W'(ADR_CTRL));
  assign wrStat = wrEn && (addr == ADDR_W'(ADR_STAT));
  assign clrFlag = wrStat ? wrData[CH_COUNT-1:0] : '0;
  assign clrOvr = wrStat ? wrData[2*CH_COUNT-1:CH_COUNT] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncPrev <= '0;
    end else begin
      syncA <= evtIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairMode <= 1'b0;
      edgePol <= '0;
      irqEn <= '0;
    end else if (wrCtrl) begin
      pairMode <= wrData[0];
      edgePol <= wrData[CH_COUNT:1];
      irqEn <= wrData[2*CH_COUNT:CH_COUNT+1];
    end
  end

  generate
    for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
      if (i < 2) begin : g_shared
        assign capEn[i] = pairMode;
      end else begin : g_own
        assign capEn[i] = 1'b1;
      end

      assign edgeHit[i] = edgePol[i] ? (syncPrev[i] & ~syncB[i])
                                     : (syncB[i] & ~syncPrev[i]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          flags[i] <= 1'b0;
          ovr[i] <= 1'b0;
        end else begin
          flags[i] <= strb.cap[i] | (flags[i] & ~clrFlag[i]);
          ovr[i] <= (strb.cap[i] & flags[i] & ~clrFlag[i]) | (ovr[i] & ~clrOvr[i]);
        end
      end
    end
  endgenerate

  always_comb begin
    strb.cap = edgeHit & capEn;
    strb.wrReload = wrEn && (addr == ADDR_W'(ADR_CAP0));
    strb.wrTimer = wrEn && (addr == ADDR_W'(ADR_CAP0 + 1));
    strb.pairCapture = pairMode;
  end

  assign ctrlWord = {irqEn, edgePol, pairMode};
  assign statWord = {ovr, flags};
  assign irq = |(flags & irqEn);
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRESCALE = 8,
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [CH_COUNT-1:0] evtIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic irq,
  output logic underflow
);
  ctmr_strb_t strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capRegs [CH_COUNT];
  logic [CTRL_W-1:0] ctrlWord;
  logic [STAT_W-1:0] statWord;

  ctmr_control #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_control (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .strb(strb), .ctrlWord(ctrlWord), .statWord(statWord),
    .irq(irq)
  );

  ctmr_datapath #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .count(count),
    .capRegs(capRegs), .underflow(underflow)
  );

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADR_COUNT)) rdData = count;
    if (addr == ADDR_W'(ADR_CTRL)) rdData = CNT_W'(ctrlWord);
    if (addr == ADDR_W'(ADR_STAT)) rdData = CNT_W'(statWord);
    for (int i = 0; i < CH_COUNT; i++) begin
      if (addr == ADDR_W'(ADR_CAP0 + i)) rdData = capRegs[i];
    end
  end
endmodule

// File: rtl/ctmr_check.sv
module ctmr_check
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] addr,
  input logic wrEn,
  input logic [CNT_W-1:0] wrData,
  input logic irq,
  input logic underflow,
  input logic [CNT_W-1:0] count,
  input logic [STAT_W-1:0] statWord,
  input logic pairMode,
  input logic [CH_COUNT-1:0] capStb,
  input logic [CNT_W-1:0] tmrVal,
  input logic [CNT_W-1:0] lastCap
);
  logic [CH_COUNT-1:0] flags, ovr;
  assign flags = statWord[CH_COUNT-1:0];
  assign ovr = statWord[2*CH_COUNT-1:CH_COUNT];

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_count_nowrite_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADR_COUNT)) |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_cap_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastCap) |-> $past(capStb[CH_COUNT-1]));

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0));

  p_under_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> !$past(pairMode));

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pairMode && !(wrEn && addr == ADDR_W'(ADR_CAP0 + 1)) && !capStb[1]) |=> $stable(tmrVal));

  generate
    for (genvar i = 0; i < CH_COUNT; i++) begin : g_chk
      p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
        (flags[i] && !(wrEn && addr == ADDR_W'(ADR_STAT) && wrData[i])) |=> flags[i]);

      p_ovr_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ovr[i]) |-> $past(flags[i]));
    end
  endgenerate
endmodule

bind ctmr_top ctmr_check #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_check (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .irq(irq), .underflow(underflow), .count(count), .statWord(statWord),
  .pairMode(strb.pairCapture), .capStb(strb.cap), .tmrVal(capRegs[1]),
  .lastCap(capRegs[2])
);

// File: tb/ctmr_top_test.sv
module ctmr_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] evtIn = '0;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic irq, underflow;

  int nChecks = 0;
  int nBad = 0;
  int peek = 0;
  bit done = 0;

  // behavioural model state
  int mPre, mCnt;
  bit [2:0] m1, m2, m3, mPol, mIe, mFlag, mOvr;
  bit mMode, mUnder;
  logic [15:0] mCap [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctmr_top #(.CNT_W(16), .PRESCALE(PRE), .ADDR_W(4)) uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .underflow(underflow)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; m1 = 0; m2 = 0; m3 = 0; mPol = 0; mIe = 0;
      mFlag = 0; mOvr = 0; mMode = 0; mUnder = 0;
      for (int i = 0; i < 3; i++) mCap[i] = '0;
    end else begin
      bit tk;
      int nCnt;
      bit [2:0] cap, clrF, clrO;
      logic [15:0] oldRel;
      tk = (mPre == PRE - 1);
      nCnt = tk ? ((mCnt + 1) & 16'hFFFF) : mCnt;
      for (int i = 0; i < 3; i++) begin
        bit e;
        e = mPol[i] ? (m3[i] && !m2[i]) : (m2[i] && !m3[i]);
        cap[i] = e && (i == 2 || mMode);
      end
      clrF = (wrEn && addr == 2) ? wrData[2:0] : 3'b0;
      clrO = (wrEn && addr == 2) ? wrData[5:3] : 3'b0;
      mOvr = (cap & mFlag & ~clrF) | (mOvr & ~clrO);
      mFlag = cap | (mFlag & ~clrF);
      oldRel = mCap[0];
      if (cap[0]) mCap[0] = nCnt[15:0];
      else if (wrEn && addr == 3) mCap[0] = wrData;
      mUnder = 0;
      if (cap[1]) mCap[1] = nCnt[15:0];
      else if (wrEn && addr == 4) mCap[1] = wrData;
      else if (!mMode && tk) begin
        if (mCap[1] == 0) begin mCap[1] = oldRel; mUnder = 1; end
        else mCap[1] = mCap[1] - 1;
      end
      if (cap[2]) mCap[2] = nCnt[15:0];
      if (wrEn && addr == 1) begin
        mMode = wrData[0]; mPol = wrData[3:1]; mIe = wrData[6:4];
      end
      mPre = tk ? 0 : mPre + 1;
      mCnt = nCnt;
      m3 = m2; m2 = m1; m1 = evtIn;
    end
  end

  function automatic logic [15:0] modelRd(int a);
    case (a)
      0: return mCnt[15:0];
      1: return {9'b0, mIe, mPol, mMode};
      2: return {10'b0, mOvr, mFlag};
      3, 4, 5: return mCap[a-3];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tagFor(int a);
    case (a)
      0: return "R1";
      1: return "R4";
      2: return "R5";
      3, 4: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(tagFor(int'(addr)), rdData, modelRd(int'(addr)));
      chk("R6", {15'b0, irq}, {15'b0, |(mFlag & mIe)});
      chk("R8", {15'b0, underflow}, {15'b0, mUnder});
    end
  end

  task automatic step1();
    @(negedge clk); #1;
    wrEn = 1'b0; addr = 4'(peek); peek = (peek + 1) % 6;
  endtask

  task automatic idle(int n);
    repeat (n) step1();
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    addr = 4'(a); wrData = 16'(d); wrEn = 1'b1;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic dcheck(int a, string tag);
    @(negedge clk); #1;
    wrEn = 1'b0; addr = 4'(a);
    #1 chk(tag, rdData, modelRd(a));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    // R11: reset state on every address and both outputs
    for (int a = 0; a < 6; a++) begin
      @(negedge clk); #1 addr = 4'(a);
      #1 chk("R11", rdData, 16'h0);
    end
    chk("R11", {14'b0, irq, underflow}, 16'h0);
    @(negedge clk); #1 rstN = 1'b1;

    wr(1, 16'h0070);              // all interrupts on, rising edges, mode 0
    wr(3, 5);
    wr(4, 3);
    idle(40);                     // R8 underflow pulses compared each clock

    // R8: inputs 0 and 1 ignored in mode 0
    evtIn[0] = 1'b1; evtIn[1] = 1'b1;
    idle(5);
    dcheck(2, "R8");
    dcheck(3, "R8");
    evtIn[0] = 1'b0; evtIn[1] = 1'b0;
    idle(3);

    // R3: rising capture on input 2, R6 interrupt
    evtIn[2] = 1'b1;
    idle(4);
    dcheck(5, "R3");
    dcheck(2, "R5");
    chk("R6", {15'b0, irq}, 16'h1);

    // R7: second capture without clearing
    evtIn[2] = 1'b0; idle(3);
    evtIn[2] = 1'b1; idle(4);
    dcheck(2, "R7");
    dcheck(5, "R7");

    // R5: write-1 clear
    wr(2, 16'h003F);
    dcheck(2, "R5");
    chk("R6", {15'b0, irq}, 16'h0);

    // R4: falling-edge selection
    wr(1, 16'h0078);
    evtIn[2] = 1'b0;
    idle(4);
    dcheck(5, "R4");
    dcheck(2, "R4");

    // R12: clear in same cycle as capture; flag must survive
    evtIn[2] = 1'b1; idle(3);
    evtIn[2] = 1'b0;
    step1();
    wr(2, 16'h003F);
    dcheck(2, "R12");

    // R9: pair-capture mode
    wr(1, 16'h0079);
    evtIn[0] = 1'b1; idle(4);
    dcheck(3, "R9");
    evtIn[1] = 1'b1; idle(4);
    dcheck(4, "R9");
    idle(10);
    dcheck(4, "R9");

    // R12: capture wins over write to same register
    evtIn[0] = 1'b0; idle(3);
    evtIn[0] = 1'b1;
    step1();
    wr(3, 16'hBEEF);
    dcheck(3, "R12");

    // R2: write to timebase ignored
    wr(0, 16'h1234);
    dcheck(0, "R2");
    idle(7);
    dcheck(0, "R1");

    // R10: capture on the wrap step
    wr(1, 16'h0070);
    evtIn = '0;
    idle(4);
    while (!(mCnt == 16'hFFFE && mPre == 1)) step1();
    evtIn[2] = 1'b1;
    idle(4);
    dcheck(5, "R10");
    chk("R10", rdData, 16'h0000);
    dcheck(0, "R1");

    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule